// File: doc/BRIEF.md
# Keyboard Scan Code Decoder

This block follows a keyboard byte receiver. Each received scan-code byte arrives with a one-cycle valid strobe. The block absorbs the two prefix bytes into flags: 0xE0 marks an extended key and 0xF0 marks a key release. Both flags travel with the next real key code, and the block then clears them.

The block keeps a level that shows whether a shift key is held. It uses that level to turn key codes into lower-case or upper-case ASCII, and into digits or their shifted symbols. Each key event (scan code, two flags and ASCII byte) is held in output registers behind a ready/read handshake. The consumer sees `ready` rise and pulses `rd_ack` once it has taken the event.

The parameter `TRAP_SHIFT` controls shift trapping. When it is non-zero, shift keys produce no event and show up only on `shift_held`. When it is zero, shift keys produce events like any other key.

Top module: `kbd_code_decoder`

## Requirements
- R1: A valid byte of 0xE0 produces no event and sets a pending extended flag for the next non-prefix code.
- R2: A valid byte of 0xF0 produces no event and sets a pending release flag for the next non-prefix code.
- R3: Every non-prefix code carries the pending flags on `key_ext` and `key_rel`, and both pending flags clear after it, so the following key shows both flags at 0.
- R4: The pending flags also clear on a non-prefix code whose event is suppressed, such as a trapped shift key.
- R5: Codes 0x12 (left shift) and 0x59 (right shift) set `shift_held` when they arrive without a pending release. Either code clears `shift_held` when it arrives with a pending release.
- R6: With `TRAP_SHIFT` non-zero, a shift code produces no event. `ready` stays low and the held outputs do not change.
- R7: With `TRAP_SHIFT` zero, a shift code produces an event that shows the shift code and ASCII 0x00.
- R8: The ASCII mapping is as follows. Letters give lower case (0x61..0x7A) when shift is not held and upper case (0x41..0x5A) when it is held. Digit keys give 0x30..0x39, or `!@#$%^&*()` for 1..9,0 when shift is held. Space 0x29 gives 0x20, enter 0x5A gives 0x0D, and tab 0x0D gives 0x09. The extended flag does not change the mapping.
- R9: A code with no mapping gives ASCII 0x00 and still presents its scan code and flags. For example, 0x11 with and without the extended flag tells the two Alt keys apart.
- R10: `ready` rises in the cycle after the valid byte of an emitting code. It stays high with stable outputs until a cycle with `rd_ack` high, after which it falls.
- R11: An event that arrives while `ready` is high replaces the held outputs. An event in the same cycle as `rd_ack` leaves `ready` high with the new event.
- R12: After reset, `ready`, `key_code`, `key_ext`, `key_rel`, `ascii` and `shift_held` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: `byte_in` holds a received byte |
| byte_in | input | 8 | Received scan-code byte |
| rd_ack | input | 1 | Consumer has taken the held event |
| ready | output | 1 | A key event is held and unread |
| key_code | output | 8 | Scan code of the held event |
| key_ext | output | 1 | Held event was preceded by the extended prefix |
| key_rel | output | 1 | Held event was preceded by the release prefix |
| ascii | output | 8 | ASCII value of the held event, 0x00 if unmapped |
| shift_held | output | 1 | A shift key is currently held |

## Verification
The hardest case to reach from the ports is a pending flag cleared by a code that produces no event. Nothing becomes visible at the moment the flag clears. To reach it, the stimulus sends both prefixes, then a trapped shift code, then a plain letter, and checks that the letter arrives with both flags at 0.

The second hard case is an event that lands in the same cycle as a read. To reach it, the bench switches off its automatic reader and leaves an event unread. It then drives a new byte together with `rd_ack` in the same cycle. A second instance with trapping disabled receives the same byte stream, so the untrapped shift events can be compared with the trapped ones.

// File: rtl/kbd_dec_pkg.sv
// Package: shared widths, special code values, event record and the
// scan-code to ASCII lookup used by the decoder.
// Assumes scan code set 2 byte values.
package kbd_dec_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] PFX_EXT   = 8'hE0;
    localparam logic [CODE_W-1:0] PFX_REL   = 8'hF0;
    localparam logic [CODE_W-1:0] SHIFT_L   = 8'h12;
    localparam logic [CODE_W-1:0] SHIFT_R   = 8'h59;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ext;
        logic              rel;
        logic [7:0]        chr;
    } key_evt_t;

    // Map a key code to its unshifted character, 0 when unmapped.
    function automatic logic [7:0] base_char(input logic [CODE_W-1:0] code);
        logic [7:0] c;
        case (code)
            8'h1C: c = "a";  8'h32: c = "b";  8'h21: c = "c";  8'h23: c = "d";
            8'h24: c = "e";  8'h2B: c = "f";  8'h34: c = "g";  8'h33: c = "h";
            8'h43: c = "i";  8'h3B: c = "j";  8'h42: c = "k";  8'h4B: c = "l";
            8'h3A: c = "m";  8'h31: c = "n";  8'h44: c = "o";  8'h4D: c = "p";
            8'h15: c = "q";  8'h2D: c = "r";  8'h1B: c = "s";  8'h2C: c = "t";
            8'h3C: c = "u";  8'h2A: c = "v";  8'h1D: c = "w";  8'h22: c = "x";
            8'h35: c = "y";  8'h1A: c = "z";
            8'h45: c = "0";  8'h16: c = "1";  8'h1E: c = "2";  8'h26: c = "3";
            8'h25: c = "4";  8'h2E: c = "5";  8'h36: c = "6";  8'h3D: c = "7";
            8'h3E: c = "8";  8'h46: c = "9";
            8'h29: c = 8'h20;
            8'h5A: c = 8'h0D;
            8'h0D: c = 8'h09;
            default: c = 8'h00;
        endcase
        return c;
    endfunction

    // Apply the shift level to an unshifted character.
    function automatic logic [7:0] shifted_char(input logic [7:0] c, input logic shift);
        logic [7:0] r;
        r = c;
        if (shift) begin
            if (c >= "a" && c <= "z") begin
                r = c - 8'h20;
            end else begin
                case (c)
                    "1": r = "!";  "2": r = "@";  "3": r = "#";  "4": r = "$";
                    "5": r = "%";  "6": r = "^";  "7": r = "&";  "8": r = "*";
                    "9": r = "(";  "0": r = ")";
                    default: r = c;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/kbd_prefix_fold.sv
// Prefix folding: absorbs extended and release prefix bytes into pending
// flags and flags each non-prefix byte as a key strobe.
// Assumes byte_vld is a single-cycle strobe per received byte.
module kbd_prefix_fold
    import kbd_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [CODE_W-1:0] byte_in,
    output logic              key_stb,
    output logic              ext_pend,
    output logic              rel_pend
);

    logic is_ext;
    logic is_rel;
    logic ext_q;
    logic rel_q;

    // Classify the incoming byte.
    always_comb begin
        is_ext  = (byte_in == PFX_EXT);
        is_rel  = (byte_in == PFX_REL);
        key_stb = byte_vld && !is_ext && !is_rel;
    end

    // Pending flags: set by prefixes, cleared by every real key code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            rel_q <= 1'b0;
        end else if (byte_vld) begin
            if (is_ext) begin
                ext_q <= 1'b1;
            end else if (is_rel) begin
                rel_q <= 1'b1;
            end else begin
                ext_q <= 1'b0;
                rel_q <= 1'b0;
            end
        end
    end

    assign ext_pend = ext_q;
    assign rel_pend = rel_q;

endmodule

// File: rtl/kbd_shift_track.sv
// Shift tracking: keeps the shift-held level from make and break codes of
// either shift key and decides whether a key strobe emits an event.
// Assumes rel_pend reflects the prefix state before the current key.
module kbd_shift_track
    import kbd_dec_pkg::*;
#(
    parameter int TRAP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_stb,
    input  logic [CODE_W-1:0] code,
    input  logic              rel_pend,
    output logic              shift_lvl,
    output logic              emit
);

    logic is_shift;
    logic shift_q;

    // Recognise either shift key code.
    assign is_shift = (code == SHIFT_L) || (code == SHIFT_R);

    // Shift level: make sets it, release-prefixed code clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= 1'b0;
        end else if (key_stb && is_shift) begin
            shift_q <= !rel_pend;
        end
    end

    assign shift_lvl = shift_q;

    // Emission policy selected by the trap parameter.
    generate
        if (TRAP != 0) begin : g_trap
            assign emit = key_stb && !is_shift;
        end else begin : g_pass
            assign emit = key_stb;
        end
    endgenerate

endmodule

// File: rtl/kbd_event_hold.sv
// Event holding register: captures an emitted key event and raises ready
// until the consumer acknowledges; a new event overrides a pending read.
// Assumes rd_ack is sampled on the same clock.
module kbd_event_hold
    import kbd_dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  key_evt_t evt_in,
    input  logic     rd_ack,
    output logic     ready,
    output key_evt_t evt_out
);

    key_evt_t evt_q;
    logic     rdy_q;

    // Held event: overwritten on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else if (load) begin
            evt_q <= evt_in;
        end
    end

    // Ready level: load wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
        end else if (load) begin
            rdy_q <= 1'b1;
        end else if (rd_ack) begin
            rdy_q <= 1'b0;
        end
    end

    assign ready   = rdy_q;
    assign evt_out = evt_q;

endmodule

// File: rtl/kbd_code_decoder.sv
// Top: folds scan-code prefixes into per-key flags, tracks shift, maps key
// codes to ASCII and holds each event behind a ready/read handshake.
// Assumes one received byte per byte_vld pulse from an upstream receiver.
module kbd_code_decoder
    import kbd_dec_pkg::*;
#(
    parameter int TRAP_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              rd_ack,
    output logic              ready,
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_rel,
    output logic [7:0]        ascii,
    output logic              shift_held
);

    logic     key_stb;
    logic     ext_pend;
    logic     rel_pend;
    logic     shift_lvl;
    logic     emit;
    key_evt_t evt_new;
    key_evt_t evt_cur;

    kbd_prefix_fold u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .key_stb  (key_stb),
        .ext_pend (ext_pend),
        .rel_pend (rel_pend)
    );

    kbd_shift_track #(.TRAP(TRAP_SHIFT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_stb   (key_stb),
        .code      (byte_in),
        .rel_pend  (rel_pend),
        .shift_lvl (shift_lvl),
        .emit      (emit)
    );

    // Assemble the event from the current code, pending flags and shift level.
    always_comb begin
        evt_new.code = byte_in;
        evt_new.ext  = ext_pend;
        evt_new.rel  = rel_pend;
        evt_new.chr  = shifted_char(base_char(byte_in), shift_lvl);
    end

    kbd_event_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (emit),
        .evt_in  (evt_new),
        .rd_ack  (rd_ack),
        .ready   (ready),
        .evt_out (evt_cur)
    );

    assign key_code   = evt_cur.code;
    assign key_ext    = evt_cur.ext;
    assign key_rel    = evt_cur.rel;
    assign ascii      = evt_cur.chr;
    assign shift_held = shift_lvl;

endmodule

// File: rtl/kbd_dec_chk.sv
// Checker: port-level properties of the decoder handshake and filtering.
module kbd_dec_chk #(
    parameter int TRAP = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic [7:0] byte_in,
    input logic       rd_ack,
    input logic       ready,
    input logic [7:0] key_code,
    input logic [7:0] ascii
);

    logic pfx;
    logic shf;
    logic evt;

    assign pfx = (byte_in == 8'hE0) || (byte_in == 8'hF0);
    assign shf = (byte_in == 8'h12) || (byte_in == 8'h59);
    assign evt = byte_vld && !pfx && !((TRAP != 0) && shf);

    p_evt_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> ready);

    p_evt_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (key_code == $past(byte_in)));

    // Covers R1 and R2: prefixes never raise ready.
    p_prefix_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && pfx && !ready && !rd_ack) |=> !ready);

    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !evt) |=> !ready);

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rd_ack && !evt) |=> (ready && $stable(key_code) && $stable(ascii)));

    p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((TRAP != 0) && byte_vld && shf && !ready) |=> !ready);

    p_shift_noascii_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ((key_code == 8'h12) || (key_code == 8'h59))) |-> (ascii == 8'h00));

endmodule

bind kbd_code_decoder kbd_dec_chk #(.TRAP(TRAP_SHIFT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .rd_ack   (rd_ack),
    .ready    (ready),
    .key_code (key_code),
    .ascii    (ascii)
);

// File: tb/sim_kbd_code_decoder.sv
module sim_kbd_code_decoder;

    typedef struct {
        logic [7:0] code;
        logic       ext;
        logic       rel;
        logic [7:0] chr;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       mon_ack = 1'b0;
    logic       man_ack = 1'b0;
    logic       auto_rd = 1'b0;
    logic       rd_ack;
    logic       ready, key_ext, key_rel, shift_held;
    logic [7:0] key_code, ascii;
    logic       ready1, key_ext1, key_rel1, shift_held1;
    logic [7:0] key_code1, ascii1;

    int   vectors = 0;
    int   fails = 0;
    exp_t sb[$];

    assign rd_ack = mon_ack | man_ack;

    always #2 clk = ~clk;

    kbd_code_decoder #(.TRAP_SHIFT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .rd_ack(rd_ack), .ready(ready), .key_code(key_code), .key_ext(key_ext),
        .key_rel(key_rel), .ascii(ascii), .shift_held(shift_held)
    );

    kbd_code_decoder #(.TRAP_SHIFT(0)) u1 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .rd_ack(1'b1), .ready(ready1), .key_code(key_code1), .key_ext(key_ext1),
        .key_rel(key_rel1), .ascii(ascii1), .shift_held(shift_held1)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Drive one byte for one cycle; returns at the negedge after capture.
    task automatic send_raw(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: push the expected event, then drive the key code.
    task automatic send_key(input logic [7:0] b, input logic e, input logic r,
                            input logic [7:0] c, input string req);
        exp_t x;
        x.code = b; x.ext = e; x.rel = r; x.chr = c; x.req = req;
        sb.push_back(x);
        send_raw(b);
        idle(2);
    endtask

    // Prefix or trapped byte: nothing expected.
    task automatic send_quiet(input logic [7:0] b);
        send_raw(b);
        idle(2);
    endtask

    // Monitor: pop and compare each event the design raises.
    always @(negedge clk) begin
        mon_ack = 1'b0;
        if (rst_n && auto_rd && ready) begin
            if (sb.size() == 0) begin
                vectors++;
                fails++;
                $display("FAIL R6 unexpected event: actual code %0h expected none", key_code);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(x.req, "code", {24'd0, key_code}, {24'd0, x.code});
                check(x.req, "ext",  {31'd0, key_ext}, {31'd0, x.ext});
                check(x.req, "rel",  {31'd0, key_rel}, {31'd0, x.rel});
                check(x.req, "ascii", {24'd0, ascii}, {24'd0, x.chr});
            end
            mon_ack = 1'b1;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        // R12 reset state
        check("R12", "ready", {31'd0, ready}, 0);
        check("R12", "code", {24'd0, key_code}, 0);
        check("R12", "flags", {30'd0, key_ext, key_rel}, 0);
        check("R12", "ascii", {24'd0, ascii}, 0);
        check("R12", "shift", {31'd0, shift_held}, 0);
        rst_n = 1'b1;
        auto_rd = 1'b1;
        idle(2);

        send_key(8'h1C, 0, 0, 8'h61, "R8");      // a
        send_quiet(8'hF0);                        // R2
        send_key(8'h1C, 0, 1, 8'h61, "R2");
        send_key(8'h1C, 0, 0, 8'h61, "R3");      // flags cleared
        send_quiet(8'hE0);                        // R1
        send_key(8'h11, 1, 0, 8'h00, "R9");      // right alt, unmapped
        send_key(8'h11, 0, 0, 8'h00, "R9");      // left alt
        send_quiet(8'hE0);
        send_quiet(8'hF0);
        send_key(8'h11, 1, 1, 8'h00, "R3");

        // Shift make, trapped on u0, passed on u1
        send_raw(8'h12);
        check("R7", "u1 ready", {31'd0, ready1}, 1);
        check("R7", "u1 code", {24'd0, key_code1}, 32'h12);
        check("R7", "u1 ascii", {24'd0, ascii1}, 0);
        idle(2);
        check("R5", "shift", {31'd0, shift_held}, 1);
        check("R5", "u1 shift", {31'd0, shift_held1}, 1);
        check("R6", "ready", {31'd0, ready}, 0);

        send_key(8'h1C, 0, 0, 8'h41, "R8");      // A
        send_key(8'h16, 0, 0, 8'h21, "R8");      // !
        send_key(8'h45, 0, 0, 8'h29, "R8");      // )
        send_key(8'h0D, 0, 0, 8'h09, "R8");      // tab
        send_key(8'h29, 0, 0, 8'h20, "R8");      // space
        send_quiet(8'hE0);
        send_key(8'h5A, 1, 0, 8'h0D, "R8");      // keypad enter
        send_quiet(8'hF0);
        send_quiet(8'h12);
        check("R5", "shift break", {31'd0, shift_held}, 0);
        send_quiet(8'h59);
        check("R5", "rshift make", {31'd0, shift_held}, 1);
        send_key(8'h1A, 0, 0, 8'h5A, "R8");      // Z
        send_quiet(8'hF0);
        send_quiet(8'h59);
        check("R5", "rshift break", {31'd0, shift_held}, 0);

        // R4: flags cleared by suppressed shift code
        send_quiet(8'hE0);
        send_quiet(8'h12);
        send_key(8'h1C, 0, 0, 8'h41, "R4");
        send_quiet(8'hF0);
        send_quiet(8'h12);
        send_key(8'h1C, 0, 0, 8'h61, "R4");
        send_key(8'h16, 0, 0, 8'h31, "R8");
        send_key(8'h45, 0, 0, 8'h30, "R8");
        send_key(8'h1A, 0, 0, 8'h7A, "R8");
        check("R10", "queue drained", sb.size(), 0);

        // Manual handshake: R10 and R11
        auto_rd = 1'b0;
        idle(2);
        send_raw(8'h1C);
        check("R10", "ready rise", {31'd0, ready}, 1);
        idle(3);
        check("R10", "ready held", {31'd0, ready}, 1);
        check("R10", "code held", {24'd0, key_code}, 32'h1C);
        send_raw(8'h32);
        check("R11", "overwrite code", {24'd0, key_code}, 32'h32);
        check("R11", "overwrite ascii", {24'd0, ascii}, 32'h62);
        check("R11", "ready", {31'd0, ready}, 1);
        @(negedge clk);
        byte_vld = 1'b1; byte_in = 8'h21; man_ack = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; man_ack = 1'b0;
        check("R11", "ack+event ready", {31'd0, ready}, 1);
        check("R11", "ack+event code", {24'd0, key_code}, 32'h21);
        @(negedge clk);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        check("R10", "ack clears", {31'd0, ready}, 0);
        send_raw(8'hF0);
        check("R2", "prefix no event", {31'd0, ready}, 0);
        send_raw(8'h1C);
        check("R2", "rel flag", {31'd0, key_rel}, 1);
        idle(2);

        finish_run();
    end

endmodule